// File: doc/BRIEF.md
# Parallel Dual-Load Extension Unit

This unit carries out the dual-load side operation that travels next to a main DSP instruction. It takes an 8-bit extension code and reads two 16-bit words from data memory. One word is read through a selectable address pointer and the other through the last pointer (pointer 3). Both words go to halves of the two operand pairs, AX0 and AX1. After that, the unit steps both pointers, each by one or by its own index register. Four address pointers and four index registers live inside the unit. The surrounding core loads them through a small write port and observes the pointers on a flat output bus.

An operation takes three cycles from acceptance to completion. In the first cycle the first read goes out. In the second cycle the second read goes out. In the third cycle both operand-half writes and both pointer updates take effect together, and the `done` output pulses in that cycle. The code has two layouts. In the generic layout, any of the pointers 0 to 2 can be the first pointer, and each read fills a half of a different pair. In the paired layout, pointer 0 or 1 is the first pointer, and both reads fill one pair: the first read goes to the high half and the second read to the low half. When the first pointer and pointer 3 lie in the same 1K-word region, the second read reuses the first pointer's address.

Top module: `dual_load_unit`

## Requirements
- R1: A code is a dual load only when bits 7:6 are 2'b11. Any other code causes no memory read, no operand write and no `done`, and it leaves every pointer unchanged.
- R2: When bits 1:0 are not 3, they select the first pointer (0 to 2). Bit 5 picks the AX0 half for the first read and bit 4 picks the AX1 half for the second read. A write index is {pair, half}: idx[1]=1 means AX1 and idx[0]=1 means the high half.
- R3: When bits 1:0 equal 3, bit 5 selects pointer 0 or 1 and bit 4 selects the pair. The first read writes that pair's high half and the second read writes its low half.
- R4: The second read uses pointer 3. If bits 15:10 of the first pointer equal bits 15:10 of pointer 3, the second read uses the first pointer's address instead.
- R5: `mem_re` is high for exactly two consecutive cycles. It carries the first address in the cycle after acceptance and the second address in the cycle after that. Read data returns one cycle after each read.
- R6: Bit 2 set makes the first pointer step by its own index register, otherwise by 1. Bit 3 set makes pointer 3 step by index register 3, otherwise by 1.
- R7: Pointer arithmetic wraps at 16 bits. Index values act as signed two's-complement steps.
- R8: `done` is a one-cycle pulse asserted three cycles after acceptance, together with both operand writes. The updated pointers are visible on `ar_view` in the following cycle.
- R9: Both reads use the pointer values held before the operation's own update, so back-to-back operations chain correctly.
- R10: A code presented while an operation is in flight is ignored.
- R11: After reset, all pointers and index registers are zero, and `done`, `mem_re` and both write enables are low.
- R12: The pointer write port with `ptr_waddr` 0 to 3 loads address pointers and with 4 to 7 loads index registers 0 to 3. The new value takes effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_valid | input | 1 | Extension code strobe |
| ext_code | input | 8 | Extension code |
| ptr_we | input | 1 | Pointer/index register write enable |
| ptr_waddr | input | 3 | 0-3 address pointers, 4-7 index registers |
| ptr_wdata | input | 16 | Pointer/index write value |
| mem_re | output | 1 | Data-memory read strobe |
| mem_addr | output | 16 | Data-memory read address |
| mem_rdata | input | 16 | Read data, one cycle after `mem_re` |
| ax_we_a | output | 1 | Write enable for first-read destination |
| ax_idx_a | output | 2 | First destination {pair, half} |
| ax_data_a | output | 16 | First-read data |
| ax_we_b | output | 1 | Write enable for second-read destination |
| ax_idx_b | output | 2 | Second destination {pair, half} |
| ax_data_b | output | 16 | Second-read data |
| done | output | 1 | Commit pulse |
| ar_view | output | 64 | Pointers 3..0 packed, pointer 0 in bits 15:0 |

## Verification
Some properties are checked on every cycle. `done` is a single-cycle pulse, and the operand writes appear only with it. The two write targets never coincide. A paired-layout operation writes high and then low. The read strobe forms a two-cycle burst. A non-load code never starts a read. When pointer 3 steps by one, it is one above its snapshot. Other behaviour only shows in directed scenarios checked against an independent model: the data values and addresses, the same-region aliasing, negative and wrapping steps, codes ignored while busy, and back-to-back chaining.

// File: rtl/dl_pkg.sv
package dl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD1  = 2'd1,
        ST_RD2  = 2'd2,
        ST_CMT  = 2'd3
    } dl_state_e;

    // Decoded view of one extension code
    typedef struct packed {
        logic       is_load;   // top two bits are 11
        logic       alt;       // paired-destination layout
        logic [1:0] ptr_sel;   // first pointer
        logic [1:0] dst1;      // {pair, half} for first read
        logic [1:0] dst2;      // {pair, half} for second read
        logic       first_ix;  // first pointer steps by own index
        logic       last_ix;   // pointer 3 steps by index 3
    } dl_op_t;

endpackage

// File: rtl/dl_decode.sv
module dl_decode
    import dl_pkg::*;
(
    input  logic [7:0] code,
    output dl_op_t     op
);
    always_comb begin
        op          = '0;
        op.is_load  = (code[7:6] == 2'b11);
        op.alt      = (code[1:0] == 2'b11);
        op.first_ix = code[2];
        op.last_ix  = code[3];
        if (op.alt) begin
            // pointer 0/1 via bit 5, one pair via bit 4: high then low
            op.ptr_sel = {1'b0, code[5]};
            op.dst1    = {code[4], 1'b1};
            op.dst2    = {code[4], 1'b0};
        end else begin
            op.ptr_sel = code[1:0];
            op.dst1    = {1'b0, code[5]};
            op.dst2    = {1'b1, code[4]};
        end
    end
endmodule

// File: rtl/dl_addr_gen.sv
module dl_addr_gen #(
    parameter int AW         = 16,
    parameter int REGION_LSB = 10
) (
    input  logic [AW-1:0] first_addr,
    input  logic [AW-1:0] last_addr,
    output logic [AW-1:0] second_addr,
    output logic          same_region
);
    localparam int RW = AW - REGION_LSB;

    logic [RW-1:0] region_diff;

    always_comb begin
        region_diff = first_addr[AW-1:REGION_LSB] ^ last_addr[AW-1:REGION_LSB];
        same_region = (region_diff == '0);
        second_addr = same_region ? first_addr : last_addr;
    end
endmodule

// File: rtl/dl_ptr_file.sv
module dl_ptr_file #(
    parameter int AW   = 16,
    parameter int NPTR = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [$clog2(NPTR):0]  wr_sel,
    input  logic [AW-1:0]          wr_data,
    input  logic                   upd_en,
    input  logic [$clog2(NPTR)-1:0] upd_sel,
    input  logic                   upd_first_ix,
    input  logic                   upd_last_ix,
    input  logic [AW-1:0]          base_first,
    input  logic [AW-1:0]          base_last,
    output logic [NPTR*AW-1:0]     ar_flat
);
    localparam int SW   = $clog2(NPTR);
    localparam int LAST = NPTR - 1;

    typedef struct packed {
        logic [NPTR-1:0][AW-1:0] ar;
        logic [NPTR-1:0][AW-1:0] ix;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (wr_en) begin
            if (wr_sel[SW]) d.ix[wr_sel[SW-1:0]] = wr_data;
            else            d.ar[wr_sel[SW-1:0]] = wr_data;
        end
        if (upd_en) begin
            // first pointer, then the last pointer (distinct registers)
            d.ar[upd_sel] = base_first + (upd_first_ix ? q.ix[upd_sel] : AW'(1));
            d.ar[LAST]    = base_last  + (upd_last_ix  ? q.ix[LAST]    : AW'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar g = 0; g < NPTR; g++) begin : g_view
        assign ar_flat[g*AW +: AW] = q.ar[g];
    end

    AST_LAST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_last_ix) |=> (q.ar[LAST] == $past(base_last) + AW'(1))); // R6
endmodule

// File: rtl/dual_load_unit.sv
module dual_load_unit
    import dl_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int REGION_LSB = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ext_valid,
    input  logic [7:0]          ext_code,
    input  logic                ptr_we,
    input  logic [2:0]          ptr_waddr,
    input  logic [ADDR_W-1:0]   ptr_wdata,
    output logic                mem_re,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                ax_we_a,
    output logic [1:0]          ax_idx_a,
    output logic [DATA_W-1:0]   ax_data_a,
    output logic                ax_we_b,
    output logic [1:0]          ax_idx_b,
    output logic [DATA_W-1:0]   ax_data_b,
    output logic                done,
    output logic [4*ADDR_W-1:0] ar_view
);
    localparam int NPTR = 4;
    localparam int LAST = NPTR - 1;

    typedef struct packed {
        dl_state_e         st;
        dl_op_t            op;
        logic [ADDR_W-1:0] a1;
        logic [ADDR_W-1:0] a2;
        logic [ADDR_W-1:0] last_base;
        logic [DATA_W-1:0] d1;
    } ctl_t;

    ctl_t q, d;

    dl_op_t            dec;
    logic [ADDR_W-1:0] sel_ptr;
    logic [ADDR_W-1:0] last_ptr;
    logic [ADDR_W-1:0] second_addr;
    logic              same_region;
    logic              accept;
    logic              upd_en;

    dl_decode u_dec (
        .code (ext_code),
        .op   (dec)
    );

    assign sel_ptr  = ar_view[dec.ptr_sel*ADDR_W +: ADDR_W];
    assign last_ptr = ar_view[LAST*ADDR_W +: ADDR_W];

    dl_addr_gen #(.AW(ADDR_W), .REGION_LSB(REGION_LSB)) u_agen (
        .first_addr  (sel_ptr),
        .last_addr   (last_ptr),
        .second_addr (second_addr),
        .same_region (same_region)
    );

    dl_ptr_file #(.AW(ADDR_W), .NPTR(NPTR)) u_ptrs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (ptr_we),
        .wr_sel       (ptr_waddr),
        .wr_data      (ptr_wdata),
        .upd_en       (upd_en),
        .upd_sel      (q.op.ptr_sel),
        .upd_first_ix (q.op.first_ix),
        .upd_last_ix  (q.op.last_ix),
        .base_first   (q.a1),
        .base_last    (q.last_base),
        .ar_flat      (ar_view)
    );

    always_comb begin
        d         = q;
        accept    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = q.a1;
        ax_we_a   = 1'b0;
        ax_we_b   = 1'b0;
        ax_idx_a  = q.op.dst1;
        ax_idx_b  = q.op.dst2;
        ax_data_a = q.d1;
        ax_data_b = mem_rdata;
        done      = 1'b0;
        upd_en    = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (ext_valid && dec.is_load) begin
                    accept      = 1'b1;
                    d.st        = ST_RD1;
                    d.op        = dec;
                    d.a1        = sel_ptr;
                    d.a2        = second_addr;
                    d.last_base = last_ptr;
                    d.d1        = '0;
                end
            end
            ST_RD1: begin
                mem_re   = 1'b1;
                mem_addr = q.a1;
                d.st     = ST_RD2;
            end
            ST_RD2: begin
                mem_re   = 1'b1;
                mem_addr = q.a2;
                d.d1     = mem_rdata;
                d.st     = ST_CMT;
            end
            ST_CMT: begin
                ax_we_a = 1'b1;
                ax_we_b = 1'b1;
                done    = 1'b1;
                upd_en  = 1'b1;
                d.st    = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_WRITES_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ax_we_a || ax_we_b) |-> done); // R8
    AST_DISTINCT_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        ax_we_a |-> (ax_idx_a != ax_idx_b)); // R2
    AST_PAIRED_HIGH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (done && q.op.alt) |-> (ax_idx_a[0] && !ax_idx_b[0] && ax_idx_a[1] == ax_idx_b[1])); // R3
    AST_NONLOAD_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && ext_valid && ext_code[7:6] != 2'b11) |=> !mem_re); // R1
    AST_READ_BURST_START: assert property (@(posedge clk) disable iff (!rst_n)
        (accept) |=> (mem_re && !done)); // R5
    AST_READ_BURST_END: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && $past(mem_re)) |=> !mem_re); // R5
endmodule

// File: tb/tb_dual_load_unit.sv
module tb_dual_load_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ext_valid;
    logic [7:0]  ext_code;
    logic        ptr_we;
    logic [2:0]  ptr_waddr;
    logic [15:0] ptr_wdata;
    logic        mem_re;
    logic [15:0] mem_addr;
    logic [15:0] mem_rdata;
    logic        ax_we_a, ax_we_b, done;
    logic [1:0]  ax_idx_a, ax_idx_b;
    logic [15:0] ax_data_a, ax_data_b;
    logic [63:0] ar_view;

    int checks = 0;
    int failures = 0;
    logic [15:0] m_ar [4];
    logic [15:0] m_ix [4];
    logic [15:0] log_addr [8];
    int          log_n;

    always #4 clk = ~clk;

    dual_load_unit dut (
        .clk(clk), .rst_n(rst_n), .ext_valid(ext_valid), .ext_code(ext_code),
        .ptr_we(ptr_we), .ptr_waddr(ptr_waddr), .ptr_wdata(ptr_wdata),
        .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .ax_we_a(ax_we_a), .ax_idx_a(ax_idx_a), .ax_data_a(ax_data_a),
        .ax_we_b(ax_we_b), .ax_idx_b(ax_idx_b), .ax_data_b(ax_data_b),
        .done(done), .ar_view(ar_view)
    );

    function automatic logic [15:0] mem_fn(input logic [15:0] a);
        logic [31:0] t;
        t = {16'h0, a} * 32'h9E37;
        return t[15:0] ^ 16'h5A5A;
    endfunction

    always @(posedge clk) mem_rdata <= mem_fn(mem_addr);

    always @(negedge clk) begin
        if (mem_re && log_n < 8) begin
            log_addr[log_n] = mem_addr;
            log_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_reg(input int sel, input logic [15:0] v);
        @(negedge clk);
        ptr_we = 1'b1; ptr_waddr = 3'(sel); ptr_wdata = v;
        @(negedge clk);
        ptr_we = 1'b0;
        if (sel < 4) m_ar[sel] = v; else m_ix[sel-4] = v;
    endtask

    task automatic check_ptrs(input string req);
        for (int k = 0; k < 4; k++)
            chk(ar_view[k*16 +: 16] == m_ar[k], req, 64'(ar_view[k*16 +: 16]), 64'(m_ar[k]));
    endtask

    // One dual load, optionally poked by a second code while busy (R10)
    task automatic run_load(input logic [7:0] code, input bit intrude, input string req);
        int p, lat;
        logic [15:0] a1, a2, n1, n3;
        logic [1:0]  i1, i2;
        p  = (code[1:0] == 2'b11) ? {1'b0, code[5]} : int'(code[1:0]);
        a1 = m_ar[p];
        a2 = (a1[15:10] == m_ar[3][15:10]) ? a1 : m_ar[3];
        if (code[1:0] == 2'b11) begin i1 = {code[4], 1'b1}; i2 = {code[4], 1'b0}; end
        else                    begin i1 = {1'b0, code[5]}; i2 = {1'b1, code[4]}; end
        n1 = a1 + (code[2] ? m_ix[p] : 16'd1);
        n3 = m_ar[3] + (code[3] ? m_ix[3] : 16'd1);
        @(negedge clk);
        ext_valid = 1'b1; ext_code = code; log_n = 0;
        @(negedge clk);
        lat = 1;
        if (intrude) ext_code = 8'hC1;
        else         ext_valid = 1'b0;
        while (!done && lat < 8) begin
            @(negedge clk);
            ext_valid = 1'b0;
            lat++;
        end
        chk(lat == 3, "R8 latency", 64'(lat), 64'd3);
        chk(ax_we_a && ax_we_b, "R8 writes with done", {ax_we_a, ax_we_b}, 2'b11);
        chk(ax_idx_a == i1, {req, " dst1"}, 64'(ax_idx_a), 64'(i1));
        chk(ax_idx_b == i2, {req, " dst2"}, 64'(ax_idx_b), 64'(i2));
        chk(ax_data_a == mem_fn(a1), {req, " data1"}, 64'(ax_data_a), 64'(mem_fn(a1)));
        chk(ax_data_b == mem_fn(a2), "R4 data2", 64'(ax_data_b), 64'(mem_fn(a2)));
        chk(log_n == 2, "R5 read count", 64'(log_n), 64'd2);
        chk(log_addr[0] == a1, "R9 first address", 64'(log_addr[0]), 64'(a1));
        chk(log_addr[1] == a2, "R4 second address", 64'(log_addr[1]), 64'(a2));
        @(negedge clk);
        chk(!done, "R8 single pulse", 64'(done), 64'd0);
        m_ar[p] = n1;
        m_ar[3] = n3;
        check_ptrs({req, " R6 pointer update"});
        if (intrude) begin
            repeat (4) begin
                @(negedge clk);
                chk(!done && !mem_re, "R10 busy code ignored", {done, mem_re}, 2'b00);
            end
            check_ptrs("R10 pointers");
        end
    endtask

    task automatic test_reset();
        chk(ar_view == 64'h0, "R11 pointers", ar_view, 64'h0);
        chk(!done && !mem_re && !ax_we_a && !ax_we_b, "R11 outputs",
            {done, mem_re, ax_we_a, ax_we_b}, 4'b0);
    endtask

    task automatic test_ignored(input logic [7:0] code);
        @(negedge clk);
        ext_valid = 1'b1; ext_code = code; log_n = 0;
        @(negedge clk);
        ext_valid = 1'b0;
        repeat (4) begin
            chk(!done && !mem_re && !ax_we_a, "R1 non-load ignored", {done, mem_re, ax_we_a}, 3'b0);
            @(negedge clk);
        end
        check_ptrs("R1 pointers kept");
    endtask

    task automatic test_ptr_port();
        set_reg(0, 16'h0400); set_reg(1, 16'h0800); set_reg(2, 16'h1234); set_reg(3, 16'h2000);
        set_reg(4, 16'h0003); set_reg(5, 16'hFFFE); set_reg(6, 16'h0010); set_reg(7, 16'h0100);
        check_ptrs("R12 pointer load");
    endtask

    initial begin
        rst_n = 1'b0; ext_valid = 1'b0; ext_code = 8'h0;
        ptr_we = 1'b0; ptr_waddr = 3'd0; ptr_wdata = 16'h0; log_n = 0;
        for (int k = 0; k < 4; k++) begin m_ar[k] = 16'h0; m_ix[k] = 16'h0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_ptr_port();
        // generic layout, each mode, different regions
        run_load(8'hC0, 1'b0, "R2 generic p0 mode00");
        run_load(8'hE5, 1'b0, "R2 generic p1 mode01 neg ix R7");
        run_load(8'hDA, 1'b0, "R2 generic p2 mode10");
        run_load(8'hFD, 1'b0, "R2 generic p1 mode11");
        // paired layout
        run_load(8'hC3, 1'b0, "R3 paired p0 ax0");
        run_load(8'hF7, 1'b0, "R3 paired p1 ax1 mode01");
        run_load(8'hDF, 1'b0, "R3 paired p0 ax1 mode11");
        // same 1K region collision
        set_reg(0, 16'h2C10); set_reg(3, 16'h2F00);
        run_load(8'hC0, 1'b0, "R4 same region");
        set_reg(1, 16'h3400); set_reg(3, 16'h3000);
        run_load(8'hE3, 1'b0, "R4 distinct region paired");
        // wrap-around and negative steps
        set_reg(2, 16'hFFFF); set_reg(3, 16'h0001); set_reg(7, 16'hFFFE);
        run_load(8'hCA, 1'b0, "R7 wrap");
        // back-to-back chaining
        run_load(8'hC1, 1'b0, "R9 chain a");
        run_load(8'hC1, 1'b0, "R9 chain b");
        // ignored codes
        test_ignored(8'h83);
        test_ignored(8'h40);
        // code during busy
        run_load(8'hC2, 1'b1, "R10 busy");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule